// File: doc/BRIEF.md
# Compare-Match Interval Timer Pair with Toggle Output

This block holds two 8-bit up-counting timers. Each timer advances on a count tick and compares its next value with a data register that is written from a simple write port. When the next value would equal the register, the timer clears to zero and gives a one-cycle interrupt pulse. The interrupt period is therefore the register value times the tick period, and a value of zero gives the full 256 ticks. Each timer takes its tick from one of three taps of a free-running prescaler, which divides the system clock by 4, 16 or 64. It can instead take its tick from falling edges of its own external event input, after a two-flop synchroniser. That choice turns the timer into an event counter.

A cascade control joins the two timers into a single 16-bit timer. Timer A holds the low byte and timer B the high byte. Timer A's run control, tick source and pulse enable then drive the joined timer, and its events appear on timer A's interrupt and pulse outputs. When its pulse output is enabled, a timer inverts that pin on every match, which gives a square wave with 50% duty and twice the interrupt period. Both count values sit on output ports, so they can be read at any time.

Top module: `cmt_timer_pair`

## Requirements
- R1: The prescaler counts clock cycles from reset. Tick source code 0, 1 or 2 gives a tick in every cycle where that cycle count modulo 4, 16 or 64 equals the divisor minus one. A running timer advances by one at each such tick.
- R2: At a tick where the count plus one (modulo 256) equals the data register, the count becomes 0 and the interrupt output is high for exactly the following cycle. The interrupt period is the register value in ticks, and a value of 0 gives 256 ticks.
- R3: After reset, and in any cycle after its run input has been low, a timer's count is 0 and its interrupt and pulse outputs are low.
- R4: A write (wr_en high, wr_sel 0 selects timer A and 1 selects timer B) loads the data register only if that timer is stopped. A write made while the timer runs leaves the compare value unchanged.
- R5: Tick source code 3 counts falling edges of the timer's event input, and only while its event enable is high. The input passes through two synchronising flops, so the count advances at the third rising clock edge after the input falls.
- R6: With cascade high, timer A's run input, tick source and pulse enable control a 16-bit timer. The count is {count_b, count_a} and the compare value is {data B, data A}, and both follow the rules of R2 with modulo 65536. The interrupt and pulse appear on irq_a and pulse_a. In this mode irq_b and pulse_b stay low, and writes to either register are accepted only while run_a is low.
- R7: While the pulse enable is high, the pulse output inverts on every match of R2 or R6, so it changes in the same cycle the interrupt rises.
- R8: While the pulse enable is low, the pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Data register write strobe |
| wr_sel | input | 1 | Write target: 0 timer A, 1 timer B |
| wr_data | input | 8 | Data register write value |
| run_a | input | 1 | Timer A run (joined timer in cascade) |
| run_b | input | 1 | Timer B run (ignored in cascade) |
| cascade | input | 1 | Join both timers into one 16-bit timer |
| src_a | input | 2 | Timer A tick source: 0 /4, 1 /16, 2 /64, 3 event |
| src_b | input | 2 | Timer B tick source, same codes |
| pulse_en_a | input | 1 | Timer A toggle output enable |
| pulse_en_b | input | 1 | Timer B toggle output enable |
| evt_a | input | 1 | Timer A external event input |
| evt_b | input | 1 | Timer B external event input |
| evt_en_a | input | 1 | Timer A event input enable |
| evt_en_b | input | 1 | Timer B event input enable |
| count_a | output | 8 | Timer A current count |
| count_b | output | 8 | Timer B current count |
| irq_a | output | 1 | Timer A match interrupt pulse |
| irq_b | output | 1 | Timer B match interrupt pulse |
| pulse_a | output | 1 | Timer A toggle output |
| pulse_b | output | 1 | Timer B toggle output |

## Verification
Two timers run at the same time at the /4 and /16 taps with small compare values, so a mistake in the tap spacing or in the match offset shows up as a drift against the model within a few periods. A write while a timer runs, followed by a stop, separates correct write gating and stop clearing from an update that leaks through. A register value of zero at the /4 tap tells the 256-tick wrap apart from an immediate match. Event pulses are sent with the enable first low and then high, which separates the enable gating and the synchroniser latency from plain edge counting. A cascaded run with a compare value above 255 shows the carry into the high byte and the joined clear.

// File: rtl/cmt_pkg.sv
// Shared definitions for the compare-match timer pair.
// Assumes: tick source codes are fixed by the port encoding in the brief.
package cmt_pkg;
    typedef enum logic [1:0] {
        SRC_DIV_LO  = 2'd0,
        SRC_DIV_MID = 2'd1,
        SRC_DIV_HI  = 2'd2,
        SRC_EVENT   = 2'd3
    } cmt_src_e;
endpackage

// File: rtl/cmt_prescaler.sv
// Free-running prescaler giving three tick taps of the system clock.
// Assumes: every divisor is a power of two and DIV_LO <= DIV_MID <= DIV_HI.
module cmt_prescaler #(
    parameter int DIV_LO  = 4,
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_lo,
    output logic tick_mid,
    output logic tick_hi
);
    localparam int PSW = $clog2(DIV_HI);
    localparam logic [PSW-1:0] M_LO  = PSW'(DIV_LO - 1);
    localparam logic [PSW-1:0] M_MID = PSW'(DIV_MID - 1);
    localparam logic [PSW-1:0] M_HI  = PSW'(DIV_HI - 1);

    logic [PSW-1:0] ps_q;

    // Cycle counter, wraps at DIV_HI.
    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_q + 1'b1;
    end

    // Tap decode: a tap fires when its low bits are all ones.
    always_comb begin
        tick_lo  = (ps_q & M_LO)  == M_LO;
        tick_mid = (ps_q & M_MID) == M_MID;
        tick_hi  = (ps_q & M_HI)  == M_HI;
    end

    // A slow tap can only fire together with the faster taps.
    assert_taps_nested_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_hi |-> (tick_mid && tick_lo));
endmodule

// File: rtl/cmt_edge_sync.sv
// Two-flop synchroniser with falling-edge detect for an external event input.
// Assumes: the event input is asynchronous and stays low or high for at least two clocks.
module cmt_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic en,
    output logic fall
);
    logic [2:0] sh_q;

    // Shift the input through two synchroniser flops and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= 3'b111;
        else        sh_q <= {sh_q[1:0], din};
    end

    // Falling edge, gated by the enable.
    always_comb fall = en & sh_q[2] & ~sh_q[1];

    // A detected edge never repeats in the next cycle.
    assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/cmt_channel.sv
// One 8-bit counter byte with its data register.
// Assumes: the parent decides when a tick counts, whether it increments and whether it clears.
module cmt_channel #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         inc,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt,
    output logic [W-1:0] dr
);
    // Counter: cleared while stopped, clears or increments on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick) begin
            if (clr)      cnt <= '0;
            else if (inc) cnt <= cnt + 1'b1;
        end
    end

    // Data register: loads only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)         dr <= '0;
        else if (wr && !run) dr <= wr_data;
    end

    // Compare value is frozen while running.
    assert_dr_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(dr));
    // Stopping clears the count.
    assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/cmt_outgen.sv
// Interrupt pulse and toggle output for one timer.
// Assumes: fire is high for at most one cycle in a row.
module cmt_outgen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fire,
    input  logic pulse_en,
    output logic irq,
    output logic pulse
);
    // One-cycle interrupt after a match.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= run & fire;
    end

    // Toggle output: low when stopped or disabled, inverts on each match.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !pulse_en) pulse <= 1'b0;
        else if (fire)                   pulse <= ~pulse;
    end

    assert_irq_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_pulse_with_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> irq);
endmodule

// File: rtl/cmt_timer_pair.sv
// Two compare-match timers with prescaler, event inputs, toggle outputs and a 16-bit cascade.
// Assumes: a cascade change is made while both timers are stopped.
module cmt_timer_pair #(
    parameter int W       = 8,
    parameter int DIV_LO  = 4,
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         run_a,
    input  logic         run_b,
    input  logic         cascade,
    input  logic [1:0]   src_a,
    input  logic [1:0]   src_b,
    input  logic         pulse_en_a,
    input  logic         pulse_en_b,
    input  logic         evt_a,
    input  logic         evt_b,
    input  logic         evt_en_a,
    input  logic         evt_en_b,
    output logic [W-1:0] count_a,
    output logic [W-1:0] count_b,
    output logic         irq_a,
    output logic         irq_b,
    output logic         pulse_a,
    output logic         pulse_b
);
    import cmt_pkg::*;

    localparam int NCH = 2;
    localparam int W2  = 2 * W;

    logic tick_lo, tick_mid, tick_hi;
    logic [NCH-1:0] evt_in, evt_en, fall, tick_src, tick_eff;
    logic [NCH-1:0] run_eff, run_out, inc, clr, wr_hit, fire, pen, irq_v, pulse_v;
    logic [NCH-1:0] match_sep;
    logic [1:0]     src [NCH];
    logic [W-1:0]   cnt [NCH];
    logic [W-1:0]   dr  [NCH];
    logic [W2-1:0]  cnt16, dr16;
    logic           match16;

    cmt_prescaler #(.DIV_LO(DIV_LO), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) i_ps (
        .clk(clk), .rst_n(rst_n),
        .tick_lo(tick_lo), .tick_mid(tick_mid), .tick_hi(tick_hi)
    );

    // Gather per-timer inputs into arrays.
    always_comb begin
        evt_in = {evt_b, evt_a};
        evt_en = {evt_en_b, evt_en_a};
        pen    = {pulse_en_b, pulse_en_a};
        src[0] = src_a;
        src[1] = src_b;
    end

    // Joined 16-bit compare.
    always_comb begin
        cnt16   = {cnt[1], cnt[0]};
        dr16    = {dr[1], dr[0]};
        match16 = (cnt16 + 1'b1) == dr16;
    end

    // Cascade routing: timer B follows timer A's run and tick.
    always_comb begin
        run_eff[0]  = run_a;
        run_eff[1]  = cascade ? run_a : run_b;
        run_out[0]  = run_a;
        run_out[1]  = run_b & ~cascade;
        tick_eff[0] = tick_src[0];
        tick_eff[1] = cascade ? tick_src[0] : tick_src[1];
        inc[0]      = 1'b1;
        inc[1]      = cascade ? (cnt[0] == {W{1'b1}}) : 1'b1;
        clr[0]      = cascade ? match16 : match_sep[0];
        clr[1]      = cascade ? match16 : match_sep[1];
        fire[0]     = tick_eff[0] & clr[0];
        fire[1]     = tick_eff[1] & clr[1] & ~cascade;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cmt_edge_sync i_sync (
            .clk(clk), .rst_n(rst_n), .din(evt_in[i]), .en(evt_en[i]), .fall(fall[i])
        );

        // Tick source select for this timer.
        always_comb begin
            unique case (cmt_src_e'(src[i]))
                SRC_DIV_LO:  tick_src[i] = tick_lo;
                SRC_DIV_MID: tick_src[i] = tick_mid;
                SRC_DIV_HI:  tick_src[i] = tick_hi;
                default:     tick_src[i] = fall[i];
            endcase
        end

        // Standalone match and write decode.
        always_comb begin
            match_sep[i] = W'(cnt[i] + 1'b1) == dr[i];
            wr_hit[i]    = wr_en & (wr_sel == 1'(i));
        end

        cmt_channel #(.W(W)) i_ch (
            .clk(clk), .rst_n(rst_n), .run(run_eff[i]), .tick(tick_eff[i]),
            .inc(inc[i]), .clr(clr[i]), .wr(wr_hit[i]), .wr_data(wr_data),
            .cnt(cnt[i]), .dr(dr[i])
        );

        cmt_outgen i_out (
            .clk(clk), .rst_n(rst_n), .run(run_out[i]), .fire(fire[i]),
            .pulse_en(pen[i]), .irq(irq_v[i]), .pulse(pulse_v[i])
        );
    end

    // Drive the output ports.
    always_comb begin
        count_a = cnt[0];
        count_b = cnt[1];
        irq_a   = irq_v[0];
        irq_b   = irq_v[1];
        pulse_a = pulse_v[0];
        pulse_b = pulse_v[1];
    end

    assert_cascade_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cascade |=> !irq_b);
    assert_irq_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |-> (count_a == '0));
endmodule

// File: tb/test_cmt_timer_pair.sv
// Bench: behavioural reference model stepped on every rising edge, compared on every falling edge.
module test_cmt_timer_pair;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, wr_sel = 0, run_a = 0, run_b = 0, cascade = 0;
    logic [7:0] wr_data = 0;
    logic [1:0] src_a = 0, src_b = 0;
    logic pulse_en_a = 0, pulse_en_b = 0, evt_a = 1, evt_b = 1, evt_en_a = 0, evt_en_b = 0;
    logic [7:0] count_a, count_b;
    logic irq_a, irq_b, pulse_a, pulse_b;

    always #10 clk = ~clk;

    cmt_timer_pair i_cmt_timer_pair (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .run_a(run_a), .run_b(run_b), .cascade(cascade), .src_a(src_a), .src_b(src_b),
        .pulse_en_a(pulse_en_a), .pulse_en_b(pulse_en_b), .evt_a(evt_a), .evt_b(evt_b),
        .evt_en_a(evt_en_a), .evt_en_b(evt_en_b), .count_a(count_a), .count_b(count_b),
        .irq_a(irq_a), .irq_b(irq_b), .pulse_a(pulse_a), .pulse_b(pulse_b)
    );

    int checks = 0, fails = 0, cyc = 0, irq_seen = 0;
    bit done = 0;
    string tag = "R3";

    // Reference model state.
    int ps = 0;
    int m_cnt [2], m_dr [2], m_irq [2], m_pulse [2];
    bit q1 [2], q2 [2], q3 [2];

    always @(posedge clk) begin
        bit tl, tm, th, casc;
        bit t [2];
        bit fall [2];
        bit ren [2];
        bit rout [2];
        bit pe [2];
        int sel [2];
        cyc++;
        if (!rst_n) begin
            ps = 0;
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_dr[i] = 0; m_irq[i] = 0; m_pulse[i] = 0;
                q1[i] = 1; q2[i] = 1; q3[i] = 1;
            end
        end else begin
            tl = (ps % 4) == 3; tm = (ps % 16) == 15; th = (ps % 64) == 63;
            ps = (ps + 1) % 64;
            fall[0] = evt_en_a && q3[0] && !q2[0];
            fall[1] = evt_en_b && q3[1] && !q2[1];
            q3[0] = q2[0]; q2[0] = q1[0]; q1[0] = evt_a;
            q3[1] = q2[1]; q2[1] = q1[1]; q1[1] = evt_b;
            sel[0] = src_a; sel[1] = src_b;
            for (int i = 0; i < 2; i++)
                t[i] = (sel[i] == 0) ? tl : (sel[i] == 1) ? tm : (sel[i] == 2) ? th : fall[i];
            casc = cascade;
            pe[0] = pulse_en_a; pe[1] = pulse_en_b;
            ren[0] = run_a; ren[1] = casc ? run_a : run_b;
            rout[0] = run_a; rout[1] = run_b && !casc;
            if (casc) begin
                int full, d16;
                bit f;
                full = m_cnt[1] * 256 + m_cnt[0];
                d16 = m_dr[1] * 256 + m_dr[0];
                f = run_a && t[0] && (((full + 1) % 65536) == d16);
                if (!run_a) begin m_cnt[0] = 0; m_cnt[1] = 0; end
                else if (t[0]) begin
                    full = f ? 0 : (full + 1) % 65536;
                    m_cnt[0] = full % 256; m_cnt[1] = full / 256;
                end
                m_irq[0] = f; m_irq[1] = 0;
                if (!run_a || !pe[0]) m_pulse[0] = 0; else if (f) m_pulse[0] = !m_pulse[0];
                m_pulse[1] = 0;
            end else begin
                for (int i = 0; i < 2; i++) begin
                    bit f;
                    f = ren[i] && t[i] && (((m_cnt[i] + 1) % 256) == m_dr[i]);
                    if (!ren[i]) m_cnt[i] = 0;
                    else if (t[i]) m_cnt[i] = f ? 0 : (m_cnt[i] + 1) % 256;
                    m_irq[i] = f;
                    if (!rout[i] || !pe[i]) m_pulse[i] = 0; else if (f) m_pulse[i] = !m_pulse[i];
                end
            end
            if (wr_en && !ren[wr_sel]) m_dr[wr_sel] = wr_data;
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (cyc >= 1 && !done) begin
            check("count_a", count_a, m_cnt[0]);
            check("count_b", count_b, m_cnt[1]);
            check("irq_a", irq_a, m_irq[0]);
            check("irq_b", irq_b, m_irq[1]);
            check("pulse_a", pulse_a, m_pulse[0]);
            check("pulse_b", pulse_b, m_pulse[1]);
            if (irq_a || irq_b) irq_seen++;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_dr(bit s, logic [7:0] v);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic evt_pulse_b();
        @(negedge clk) evt_b = 0;
        wait_cyc(3);
        evt_b = 1;
        wait_cyc(3);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // Reset state (R3).
        tag = "R3";
        wait_cyc(4);
        rst_n = 1;
        wait_cyc(2);
        // R1 R2 R7: two taps at once, small compare values.
        tag = "R1 R2 R7";
        write_dr(0, 8'd5);
        write_dr(1, 8'd3);
        src_a = 2'd0; src_b = 2'd1; pulse_en_a = 1; pulse_en_b = 1;
        @(negedge clk) begin run_a = 1; run_b = 1; end
        wait_cyc(400);
        // R4: writes while running must not change compare values.
        tag = "R4";
        write_dr(0, 8'd9);
        write_dr(1, 8'd1);
        wait_cyc(300);
        // R3: stop clears count and pulse.
        tag = "R3";
        @(negedge clk) begin run_a = 0; run_b = 0; end
        wait_cyc(20);
        // R2 R8: compare value 0 wraps after 256 ticks; pulse disabled.
        tag = "R2 R8";
        write_dr(0, 8'd0);
        pulse_en_a = 0;
        @(negedge clk) run_a = 1;
        wait_cyc(2200);
        @(negedge clk) run_a = 0;
        // R5: event counting, first with enable low, then high.
        tag = "R5";
        write_dr(1, 8'd4);
        src_b = 2'd3; evt_en_b = 0;
        @(negedge clk) run_b = 1;
        for (int k = 0; k < 5; k++) evt_pulse_b();
        evt_en_b = 1;
        for (int k = 0; k < 12; k++) evt_pulse_b();
        @(negedge clk) run_b = 0;
        wait_cyc(4);
        // R6 R7: cascaded 16-bit timer, compare 0x0105, run_b ignored.
        tag = "R6 R7";
        cascade = 1;
        write_dr(0, 8'h05);
        write_dr(1, 8'h01);
        src_a = 2'd0; pulse_en_a = 1;
        @(negedge clk) begin run_a = 1; run_b = 1; end
        write_dr(1, 8'h00);
        wait_cyc(3000);
        @(negedge clk) begin run_a = 0; run_b = 0; end
        wait_cyc(4);
        // Stimulus sanity: match interrupts were produced (R2).
        tag = "R2";
        check("irq pulses seen", irq_seen > 20, 1);
        finish_run();
    end
endmodule